// File: doc/BRIEF.md
# Calendar Alarm Comparator with Repeat Selection

This block watches the running calendar time and raises an alarm when it agrees with a programmed alarm setting. Five time fields take part: seconds, minutes, hours, day of month and month. Each field is an 8-bit BCD byte. A 5-bit repeat code chooses how many of these fields must agree. Fewer compared fields make the alarm repeat more often, down to once every second.

The comparison is only evaluated in a cycle where the once-per-second update strobe is high. A given matching second therefore produces exactly one alarm event. An event sets a sticky alarm flag and a matching interrupt output. Both stay high until a flag-read strobe clears them. The surrounding timekeeping logic supplies the time fields and the strobe. The register file supplies the alarm fields, the repeat code and the read strobe.

Top module: `alarm_repeat_match`

## Requirements
- R1: After a synchronous reset, `alarm_flag` and `alarm_irq` are both 0.
- R2: Repeat code 5'b11111 compares no field: every `sec_tick` raises the flag, whatever the time and alarm values are.
- R3: Repeat code 5'b11110 compares only seconds. A tick raises the flag when `now_sec == alm_sec`. A tick does not raise it when the seconds differ, even if every other field agrees.
- R4: Repeat code 5'b11100 compares seconds and minutes. A mismatch in either field blocks the alarm. Hours, date and month are ignored.
- R5: Repeat code 5'b11000 compares seconds, minutes and hours. Date and month are ignored.
- R6: Repeat code 5'b10000 compares seconds, minutes, hours and date. Month is ignored.
- R7: Repeat code 5'b00000 compares all five fields. A month mismatch alone blocks the alarm.
- R8: Every other repeat code (for example 5'b10101 or 5'b01111) behaves like 5'b00000, so all five fields are compared.
- R9: Without `sec_tick`, a full match does not set the flag. With no tick and no read, the flag keeps its value.
- R10: A `flag_rd` pulse clears `alarm_flag` and `alarm_irq` in the cycle after the pulse, provided no alarm event occurs in the same cycle.
- R11: If an alarm event and `flag_rd` occur in the same cycle, the flag stays (or becomes) 1.
- R12: The flag rises on the clock edge that samples the tick, so it is visible one cycle after the tick is presented.
- R13: `alarm_irq` is high exactly when `alarm_flag` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle strobe, once per second after the time fields update |
| flag_rd | input | 1 | One-cycle strobe: the flag register is being read, so clear the flag |
| now_sec | input | FIELD_W | Current seconds, BCD |
| now_min | input | FIELD_W | Current minutes, BCD |
| now_hour | input | FIELD_W | Current hours, BCD |
| now_date | input | FIELD_W | Current day of month, BCD |
| now_mon | input | FIELD_W | Current month, BCD |
| alm_sec | input | FIELD_W | Alarm seconds, BCD |
| alm_min | input | FIELD_W | Alarm minutes, BCD |
| alm_hour | input | FIELD_W | Alarm hours, BCD |
| alm_date | input | FIELD_W | Alarm day of month, BCD |
| alm_mon | input | FIELD_W | Alarm month, BCD |
| rpt_code | input | NUM_FIELDS | Repeat selection code (bit 4 down to bit 0) |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Alarm interrupt, active high |

## Verification
The assertions assume that `sec_tick` and `flag_rd` are single-cycle strobes sampled at clock edges. They also assume the time and alarm fields are steady in the cycle where the tick is high. The bench meets these assumptions as follows:
- It changes every input on the falling clock edge.
- It holds the fields constant around each strobe.
- It raises each strobe for exactly one cycle.

The bench exercises the repeat-code decode in two ways. It spoils one field at a time to show which fields block the alarm. It also changes only ignored fields to show that they have no effect.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int NUM_FIELDS = 5;
  localparam int FIELD_W    = 8;
  // field index order inside packed vectors
  typedef enum int {
    F_SEC  = 0,
    F_MIN  = 1,
    F_HOUR = 2,
    F_DATE = 3,
    F_MON  = 4
  } field_idx_e;
endpackage

// File: rtl/alarm_mask_decode.sv
// Turns the repeat code into a per-field compare enable.
// The legal codes are ones from the top bit followed by zeros.
// Their inverse is then a run of low ones (2^k-1), which is exactly the enable set.
// Any other pattern falls back to comparing every field.
module alarm_mask_decode #(
  parameter int NUM_FIELDS = alarm_pkg::NUM_FIELDS
) (
  input  logic [NUM_FIELDS-1:0] rpt_code,
  output logic [NUM_FIELDS-1:0] cmp_en
);
  localparam int EXT_W = NUM_FIELDS + 1;

  logic [EXT_W-1:0] inv_ext;
  logic [EXT_W-1:0] inv_inc;
  logic             code_legal;

  always_comb begin
    inv_ext    = {1'b0, ~rpt_code};
    inv_inc    = inv_ext + EXT_W'(1);
    code_legal = ((inv_ext & inv_inc) == '0);
    cmp_en     = code_legal ? ~rpt_code : '1;
  end

  // The enable set must always be a contiguous run from bit 0 (R8 fallback keeps this).
  always_comb begin
    assert_enable_contiguous_R8: assert (((({1'b0, cmp_en}) & (({1'b0, cmp_en}) + EXT_W'(1))) == '0))
      else $error("compare enable not contiguous");
  end
endmodule

// File: rtl/alarm_field_cmp.sv
// Compares each enabled field; disabled fields always agree.
module alarm_field_cmp #(
  parameter int NUM_FIELDS = alarm_pkg::NUM_FIELDS,
  parameter int FIELD_W    = alarm_pkg::FIELD_W
) (
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] now_vec,
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] alm_vec,
  input  logic [NUM_FIELDS-1:0]              cmp_en,
  output logic                               all_agree
);
  logic [NUM_FIELDS-1:0] field_ok;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    assign field_ok[g] = !cmp_en[g] || (now_vec[g] == alm_vec[g]);
  end

  assign all_agree = &field_ok;

  // With nothing enabled, agreement is unconditional (R2).
  always_comb begin
    assert_no_enable_agrees_R2: assert (cmp_en != '0 || all_agree)
      else $error("empty compare set did not agree");
  end
endmodule

// File: rtl/alarm_repeat_match.sv
module alarm_repeat_match #(
  parameter int FIELD_W    = alarm_pkg::FIELD_W,
  parameter int NUM_FIELDS = alarm_pkg::NUM_FIELDS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sec_tick,
  input  logic               flag_rd,
  input  logic [FIELD_W-1:0] now_sec,
  input  logic [FIELD_W-1:0] now_min,
  input  logic [FIELD_W-1:0] now_hour,
  input  logic [FIELD_W-1:0] now_date,
  input  logic [FIELD_W-1:0] now_mon,
  input  logic [FIELD_W-1:0] alm_sec,
  input  logic [FIELD_W-1:0] alm_min,
  input  logic [FIELD_W-1:0] alm_hour,
  input  logic [FIELD_W-1:0] alm_date,
  input  logic [FIELD_W-1:0] alm_mon,
  input  logic [NUM_FIELDS-1:0] rpt_code,
  output logic               alarm_flag,
  output logic               alarm_irq
);
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] now_vec;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] alm_vec;
  logic [NUM_FIELDS-1:0]              cmp_en;
  logic                               all_agree;
  logic                               alarm_event;

  assign now_vec = {now_mon, now_date, now_hour, now_min, now_sec};
  assign alm_vec = {alm_mon, alm_date, alm_hour, alm_min, alm_sec};

  alarm_mask_decode #(.NUM_FIELDS(NUM_FIELDS)) u_dec (
    .rpt_code (rpt_code),
    .cmp_en   (cmp_en)
  );

  alarm_field_cmp #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_cmp (
    .now_vec   (now_vec),
    .alm_vec   (alm_vec),
    .cmp_en    (cmp_en),
    .all_agree (all_agree)
  );

  assign alarm_event = sec_tick && all_agree;

  // Setting wins over clearing so that a fresh event is never lost.
  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_flag <= 1'b0;
      alarm_irq  <= 1'b0;
    end else if (alarm_event) begin
      alarm_flag <= 1'b1;
      alarm_irq  <= 1'b1;
    end else if (flag_rd) begin
      alarm_flag <= 1'b0;
      alarm_irq  <= 1'b0;
    end
  end

  assert_event_sets_flag_R12: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && all_agree) |=> alarm_flag)
    else $error("alarm event did not set flag");

  assert_read_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (flag_rd && !(sec_tick && all_agree)) |=> !alarm_flag)
    else $error("flag read did not clear flag");

  assert_hold_without_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    (!sec_tick && !flag_rd) |=> $stable(alarm_flag))
    else $error("flag changed with no strobe");

  assert_no_tick_no_rise_R9: assert property (@(posedge clk) disable iff (rst)
    (!sec_tick) |=> !$rose(alarm_flag))
    else $error("flag rose without tick");
endmodule

// File: tb/sim_alarm_repeat_match.sv
module sim_alarm_repeat_match;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sec_tick = 1'b0;
  logic       flag_rd = 1'b0;
  logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_date = '0, now_mon = '0;
  logic [7:0] alm_sec = '0, alm_min = '0, alm_hour = '0, alm_date = '0, alm_mon = '0;
  logic [4:0] rpt_code = '0;
  logic       alarm_flag, alarm_irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  alarm_repeat_match u0 (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .flag_rd(flag_rd),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_date(now_date), .now_mon(now_mon),
    .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
    .alm_date(alm_date), .alm_mon(alm_mon),
    .rpt_code(rpt_code), .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Flag and irq must agree at every check point (R13).
  task automatic check_out(input string req, input logic exp);
    check(req, alarm_flag, exp);
    check({req, " R13 irq"}, alarm_irq, exp);
  endtask

  task automatic set_alarm_default();
    alm_sec = 8'h30; alm_min = 8'h45; alm_hour = 8'h12; alm_date = 8'h15; alm_mon = 8'h06;
  endtask

  task automatic set_now(input logic [7:0] s, m, h, d, mo);
    now_sec = s; now_min = m; now_hour = h; now_date = d; now_mon = mo;
  endtask

  // Inputs change at negedge; the result is visible at the following negedge.
  task automatic pulse_tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_rd = 1'b1;
    @(negedge clk); flag_rd = 1'b0;
  endtask

  task automatic try_pattern(input string req, input logic [7:0] s, m, h, d, mo, input logic exp);
    clear_flag();
    set_now(s, m, h, d, mo);
    pulse_tick();
    check_out(req, exp);
  endtask

  task automatic t_reset();
    check_out("R1 reset", 1'b0);
  endtask

  task automatic t_every_second();
    rpt_code = 5'b11111;
    try_pattern("R2 any time", 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 1'b1);
    try_pattern("R2 other time", 8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 1'b1);
  endtask

  task automatic t_minute();
    rpt_code = 5'b11110;
    try_pattern("R3 sec match", 8'h30, 8'h00, 8'h00, 8'h01, 8'h01, 1'b1);
    try_pattern("R3 sec differ", 8'h31, 8'h45, 8'h12, 8'h15, 8'h06, 1'b0);
  endtask

  task automatic t_hour();
    rpt_code = 5'b11100;
    try_pattern("R4 match", 8'h30, 8'h45, 8'h01, 8'h02, 8'h03, 1'b1);
    try_pattern("R4 min differ", 8'h30, 8'h44, 8'h12, 8'h15, 8'h06, 1'b0);
    try_pattern("R4 sec differ", 8'h29, 8'h45, 8'h12, 8'h15, 8'h06, 1'b0);
  endtask

  task automatic t_day();
    rpt_code = 5'b11000;
    try_pattern("R5 match", 8'h30, 8'h45, 8'h12, 8'h01, 8'h11, 1'b1);
    try_pattern("R5 hour differ", 8'h30, 8'h45, 8'h13, 8'h15, 8'h06, 1'b0);
  endtask

  task automatic t_month();
    rpt_code = 5'b10000;
    try_pattern("R6 match", 8'h30, 8'h45, 8'h12, 8'h15, 8'h09, 1'b1);
    try_pattern("R6 date differ", 8'h30, 8'h45, 8'h12, 8'h16, 8'h06, 1'b0);
  endtask

  task automatic t_year();
    rpt_code = 5'b00000;
    try_pattern("R7 full match", 8'h30, 8'h45, 8'h12, 8'h15, 8'h06, 1'b1);
    try_pattern("R7 month differ", 8'h30, 8'h45, 8'h12, 8'h15, 8'h07, 1'b0);
  endtask

  task automatic t_odd_codes();
    rpt_code = 5'b10101;
    try_pattern("R8 10101 month differ", 8'h30, 8'h45, 8'h12, 8'h15, 8'h07, 1'b0);
    try_pattern("R8 10101 full match", 8'h30, 8'h45, 8'h12, 8'h15, 8'h06, 1'b1);
    rpt_code = 5'b01111;
    try_pattern("R8 01111 month differ", 8'h30, 8'h45, 8'h12, 8'h15, 8'h08, 1'b0);
  endtask

  task automatic t_no_tick();
    rpt_code = 5'b00000;
    clear_flag();
    set_now(8'h30, 8'h45, 8'h12, 8'h15, 8'h06);
    repeat (3) @(negedge clk);
    check_out("R9 no tick no set", 1'b0);
    pulse_tick();
    repeat (4) @(negedge clk);
    check_out("R9 flag holds", 1'b1);
  endtask

  task automatic t_clear_and_timing();
    rpt_code = 5'b11111;
    clear_flag();
    @(negedge clk); sec_tick = 1'b1;
    check_out("R12 not before edge", 1'b0);
    @(negedge clk); sec_tick = 1'b0;
    check_out("R12 one cycle after tick", 1'b1);
    @(negedge clk); flag_rd = 1'b1;
    check_out("R10 before read edge", 1'b1);
    @(negedge clk); flag_rd = 1'b0;
    check_out("R10 read clears", 1'b0);
  endtask

  task automatic t_collision();
    rpt_code = 5'b11111;
    clear_flag();
    pulse_tick();
    @(negedge clk); flag_rd = 1'b1; sec_tick = 1'b1;
    @(negedge clk); flag_rd = 1'b0; sec_tick = 1'b0;
    check_out("R11 event beats read", 1'b1);
    @(negedge clk); flag_rd = 1'b1; sec_tick = 1'b1;
    rpt_code = 5'b00000; now_mon = 8'h01;
    @(negedge clk); flag_rd = 1'b0; sec_tick = 1'b0;
    check_out("R11 read with no match clears", 1'b0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    set_alarm_default();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_every_second();
    t_minute();
    t_hour();
    t_day();
    t_month();
    t_year();
    t_odd_codes();
    t_no_tick();
    t_clear_and_timing();
    t_collision();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end
endmodule